// File: doc/BRIEF.md
# Classed Key Store with Event-Driven Zeroization

This block keeps the security parameters of a link encryption engine in a flat array of 32-bit registers. The array is divided into twelve slots of fixed width, and each slot belongs to a retention class. A class decides which clearing events wipe the slot. Keys are loaded and fetched through one word-wide write port and one word-wide read port. A slot reports itself valid once its highest word has been written.

Four clearing events can arrive, alone or together: end of a session, a reboot request, loss of power, and an operator zeroize command. The block works out the union of the slots those events target, drops their valid flags at once, and then overwrites the targeted words with zeros, one word per clock. While this runs a busy status is high, and a one-cycle done pulse ends the pass.

Two slots hold factory keys. They are write-once and never wiped, and the root key can never be read back. A private-key entry that is stored wrapped under the key-encryption key becomes unusable as soon as that key is cleared. While a critical-error input is high, every read is refused.

Top module: `keyvault_zeroize`

## Requirements
- R1: The slot indices and widths in bits are:
  - 0: data key, 256
  - 1: IV, 128
  - 2: session cipher key, 256
  - 3: session MAC key, 256
  - 4: key-agreement share, 384
  - 5: handshake secret, 384
  - 6: generator seed, 384
  - 7: entropy input, 512
  - 8: key-encryption key, 256
  - 9: wrapped private key, 384
  - 10: root key, 256
  - 11: master wrapping key, 256

  Word w of a slot (w below width/32) is written with wr_en. The slot's valid bit rises after its last word (index width/32-1) is written. A read returns the stored word on rd_data, together with acc_err, one cycle after rd_en.
- R2: A session-end pulse drops the valid bits of slots 0 to 5 on the next cycle and overwrites every word of those slots with zero. The other slots are left untouched.
- R3: A reboot request clears slots 0 to 6. The entropy slot 7 keeps its contents.
- R4: A power-loss indication clears slots 0 to 7. The key-encryption key in slot 8 keeps its contents.
- R5: An operator zeroize command clears slots 0 to 8 and drops the valid bit of slot 9 without overwriting it. Slots 10 and 11 stay valid and keep their contents.
- R6: A pass writes exactly one zero word per cycle, and only into targeted slots. zbusy is high for as many cycles as there are targeted words. zdone is then high for exactly one cycle, and zbusy is low in that cycle.
- R7: Events that arrive in the same cycle are served in one pass over the union of their target slots, with one done pulse.
- R8: A read of slot 10 always returns zero and raises acc_err.
- R9: A write to slot 10 or 11 while the slot is valid is ignored and raises acc_err. The valid bits of these slots never fall.
- R10: While crit_err is high, every read returns zero and raises acc_err.
- R11: A read returns zero and raises acc_err in any of these cases: the slot is invalid, the slot is being cleared, the slot index is above 11, or the word index is out of range. A write made while zbusy is high, or in a cycle in which an event fires, is ignored and raises acc_err.
- R12: After reset all valid bits, zbusy, zdone, acc_err and rd_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset, empties the store |
| wr_en | input | 1 | Write strobe |
| wr_slot | input | 4 | Slot index for the write |
| wr_word | input | 4 | Word index within the slot for the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_slot | input | 4 | Slot index for the read |
| rd_word | input | 4 | Word index within the slot for the read |
| sess_end | input | 1 | Session-end event pulse |
| reboot_req | input | 1 | Reboot event pulse |
| pwr_loss | input | 1 | Power-loss event pulse |
| op_zero | input | 1 | Operator zeroize command pulse |
| crit_err | input | 1 | Critical error, blocks all reads while high |
| rd_data | output | 32 | Read result, zero when refused |
| acc_err | output | 1 | Refused read or ignored write in the previous cycle |
| slot_valid | output | 12 | Per-slot valid flags |
| zbusy | output | 1 | Zeroization pass in progress |
| zdone | output | 1 | One-cycle pulse at the end of a pass |

## Verification
The properties assume that event inputs are single-cycle pulses sampled at a rising edge, and that read and write indices are stable across the edge that captures them. The bench drives every input on the falling edge and holds each event high for exactly one cycle. It never issues a read and a write to the same word in the same cycle. A write during a pass is applied only in the scenario that checks it is refused, so the cycle counts of every other pass are exact.

// File: rtl/keyvault_pkg.sv
package keyvault_pkg;

    localparam int WORD_W   = 32;
    localparam int NSLOT    = 12;
    localparam int KEY_BITS = 256;
    localparam int IV_BITS  = 128;
    localparam int WIDE_BITS = 384;
    localparam int ENT_BITS = 512;

    localparam int S_DEK   = 0;
    localparam int S_IV    = 1;
    localparam int S_SENC  = 2;
    localparam int S_SMAC  = 3;
    localparam int S_KAGR  = 4;
    localparam int S_HSEC  = 5;
    localparam int S_SEED  = 6;
    localparam int S_ENT   = 7;
    localparam int S_KEK   = 8;
    localparam int S_PRIV  = 9;
    localparam int S_ROOT  = 10;
    localparam int S_MWK   = 11;

    localparam int EV_SESS = 0;
    localparam int EV_BOOT = 1;
    localparam int EV_PWR  = 2;
    localparam int EV_CMD  = 3;

    typedef enum logic [2:0] {
        CL_SESSION, CL_SEED, CL_ENTROPY, CL_KEK, CL_WRAPPED, CL_FACTORY
    } zclass_e;

    function automatic int slot_bits(int s);
        case (s)
            S_IV:                              return IV_BITS;
            S_KAGR, S_HSEC, S_SEED, S_PRIV:    return WIDE_BITS;
            S_ENT:                             return ENT_BITS;
            S_DEK, S_SENC, S_SMAC, S_KEK,
            S_ROOT, S_MWK:                     return KEY_BITS;
            default:                           return 0;
        endcase
    endfunction

    function automatic int slot_words(int s);
        return slot_bits(s) / WORD_W;
    endfunction

    function automatic int slot_base(int s);
        int acc = 0;
        for (int i = 0; i < NSLOT; i++) begin
            if (i < s) acc += slot_words(i);
        end
        return acc;
    endfunction

    function automatic zclass_e slot_class(int s);
        case (s)
            S_DEK, S_IV, S_SENC, S_SMAC, S_KAGR, S_HSEC: return CL_SESSION;
            S_SEED:  return CL_SEED;
            S_ENT:   return CL_ENTROPY;
            S_KEK:   return CL_KEK;
            S_PRIV:  return CL_WRAPPED;
            default: return CL_FACTORY;
        endcase
    endfunction

    function automatic logic slot_write_once(int s);
        return (s == S_ROOT) || (s == S_MWK);
    endfunction

    function automatic logic slot_readable(int s);
        return (s != S_ROOT);
    endfunction

    function automatic logic class_hit(zclass_e c, logic [3:0] ev);
        case (c)
            CL_SESSION: return |ev;
            CL_SEED:    return ev[EV_BOOT] | ev[EV_PWR] | ev[EV_CMD];
            CL_ENTROPY: return ev[EV_PWR] | ev[EV_CMD];
            CL_KEK:     return ev[EV_CMD];
            default:    return 1'b0;
        endcase
    endfunction

    localparam int TOTAL_WORDS = slot_base(NSLOT);
    localparam int ADDR_W      = $clog2(TOTAL_WORDS);
    localparam int SLOT_W      = $clog2(NSLOT);
    localparam int WIDX_W      = $clog2(ENT_BITS / WORD_W);

    typedef struct packed {
        logic [TOTAL_WORDS-1:0][WORD_W-1:0] mem;
        logic [NSLOT-1:0]                   valid;
        logic [WORD_W-1:0]                  rd_data;
        logic                               acc_err;
    } vault_t;

    typedef struct packed {
        logic [NSLOT-1:0]  pend;
        logic [WIDX_W-1:0] word;
        logic              done;
    } wipe_t;

endpackage

// File: rtl/ks_class_map.sv
module ks_class_map
    import keyvault_pkg::*;
(
    input  logic [3:0]       ev,
    output logic [NSLOT-1:0] wipe_mask,
    output logic [NSLOT-1:0] drop_mask
);

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam zclass_e CLS = slot_class(s);
        if (CLS == CL_WRAPPED) begin : g_wrapped
            assign wipe_mask[s] = 1'b0;
            assign drop_mask[s] = ev[EV_CMD];
        end else begin : g_plain
            assign wipe_mask[s] = class_hit(CLS, ev);
            assign drop_mask[s] = class_hit(CLS, ev);
        end
    end

endmodule

// File: rtl/ks_wipe_seq.sv
module ks_wipe_seq
    import keyvault_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSLOT-1:0]  add_mask,
    output logic              wipe_we,
    output logic [ADDR_W-1:0] wipe_addr,
    output logic [NSLOT-1:0]  pend,
    output logic              busy,
    output logic              done
);

    wipe_t q, d;
    logic [SLOT_W-1:0] cur;
    logic              found;
    logic [NSLOT-1:0]  rem;

    always_comb begin
        cur   = '0;
        found = 1'b0;
        for (int s = 0; s < NSLOT; s++) begin
            if (q.pend[s] && !found) begin
                cur   = SLOT_W'(s);
                found = 1'b1;
            end
        end
        d         = q;
        rem       = q.pend;
        wipe_we   = found;
        wipe_addr = ADDR_W'(slot_base(int'(cur)) + int'(q.word));
        if (found) begin
            if (int'(q.word) == slot_words(int'(cur)) - 1) begin
                rem[cur] = 1'b0;
                d.word   = '0;
            end else begin
                d.word = q.word + 1'b1;
            end
        end
        d.pend = rem | add_mask;
        d.done = (q.pend != '0) && (d.pend == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend = q.pend;
    assign busy = |q.pend;
    assign done = q.done;

endmodule

// File: rtl/keyvault_zeroize.sv
module keyvault_zeroize
    import keyvault_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [WIDX_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [WIDX_W-1:0] rd_word,
    input  logic              sess_end,
    input  logic              reboot_req,
    input  logic              pwr_loss,
    input  logic              op_zero,
    input  logic              crit_err,
    output logic [WORD_W-1:0] rd_data,
    output logic              acc_err,
    output logic [NSLOT-1:0]  slot_valid,
    output logic              zbusy,
    output logic              zdone
);

    vault_t q, d;

    logic [3:0]        ev;
    logic [NSLOT-1:0]  wipe_mask, drop_mask, pend;
    logic              wipe_we;
    logic [ADDR_W-1:0] wipe_addr;
    logic              wr_ok, rd_ok, any_evt;
    logic [ADDR_W-1:0] waddr, raddr;

    assign ev = {op_zero, pwr_loss, reboot_req, sess_end};

    ks_class_map map_i (
        .ev        (ev),
        .wipe_mask (wipe_mask),
        .drop_mask (drop_mask)
    );

    ks_wipe_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .add_mask  (wipe_mask),
        .wipe_we   (wipe_we),
        .wipe_addr (wipe_addr),
        .pend      (pend),
        .busy      (zbusy),
        .done      (zdone)
    );

    always_comb begin
        d       = q;
        any_evt = |drop_mask;
        waddr   = ADDR_W'(slot_base(int'(wr_slot)) + int'(wr_word));
        raddr   = ADDR_W'(slot_base(int'(rd_slot)) + int'(rd_word));

        wr_ok = wr_en && !zbusy && !any_evt
             && (int'(wr_slot) < NSLOT)
             && (int'(wr_word) < slot_words(int'(wr_slot)))
             && !(slot_write_once(int'(wr_slot)) && q.valid[wr_slot]);

        if (wr_ok) begin
            d.mem[waddr] = wr_data;
            if (int'(wr_word) == slot_words(int'(wr_slot)) - 1)
                d.valid[wr_slot] = 1'b1;
        end
        if (wipe_we) d.mem[wipe_addr] = '0;
        d.valid = d.valid & ~drop_mask;

        rd_ok = rd_en && !crit_err
             && (int'(rd_slot) < NSLOT)
             && (int'(rd_word) < slot_words(int'(rd_slot)))
             && slot_readable(int'(rd_slot))
             && q.valid[rd_slot] && !pend[rd_slot] && !drop_mask[rd_slot];

        d.rd_data = rd_ok ? q.mem[raddr] : '0;
        d.acc_err = (rd_en && !rd_ok) || (wr_en && !wr_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data    = q.rd_data;
    assign acc_err    = q.acc_err;
    assign slot_valid = q.valid;

endmodule

// File: rtl/ks_checker.sv
module ks_checker
    import keyvault_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [SLOT_W-1:0] wr_slot,
    input logic              rd_en,
    input logic [SLOT_W-1:0] rd_slot,
    input logic              sess_end,
    input logic              op_zero,
    input logic              crit_err,
    input logic [WORD_W-1:0] rd_data,
    input logic              acc_err,
    input logic [NSLOT-1:0]  slot_valid,
    input logic              zbusy,
    input logic              zdone
);

    // R8
    root_unreadable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_slot == SLOT_W'(S_ROOT)) |=> (acc_err && rd_data == '0));

    // R10
    crit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && crit_err) |=> (acc_err && rd_data == '0));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zdone |=> !zdone);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zdone |-> !zbusy);

    // R2
    sess_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sess_end |=> (slot_valid[S_HSEC:S_DEK] == '0));

    // R5
    kek_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_zero |=> (!slot_valid[S_KEK] && !slot_valid[S_PRIV]));

    // R9
    root_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid[S_ROOT] |=> slot_valid[S_ROOT]);

    // R9
    mwk_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid[S_MWK] |=> slot_valid[S_MWK]);

    // R9
    once_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slot == SLOT_W'(S_MWK) && slot_valid[S_MWK]) |=> acc_err);

endmodule

bind keyvault_zeroize ks_checker chk_i (.*);

// File: tb/keyvault_zeroize_tb.sv
module keyvault_zeroize_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  wr_slot = '0, wr_word = '0, rd_slot = '0, rd_word = '0;
    logic [31:0] wr_data = '0;
    logic        sess_end = 1'b0, reboot_req = 1'b0, pwr_loss = 1'b0, op_zero = 1'b0;
    logic        crit_err = 1'b0;
    logic [31:0] rd_data;
    logic        acc_err;
    logic [11:0] slot_valid;
    logic        zbusy, zdone;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    keyvault_zeroize dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_word(wr_word), .wr_data(wr_data),
        .rd_en(rd_en), .rd_slot(rd_slot), .rd_word(rd_word),
        .sess_end(sess_end), .reboot_req(reboot_req), .pwr_loss(pwr_loss),
        .op_zero(op_zero), .crit_err(crit_err),
        .rd_data(rd_data), .acc_err(acc_err), .slot_valid(slot_valid),
        .zbusy(zbusy), .zdone(zdone)
    );

    function automatic int nwords(int s);
        case (s)
            1:          return 4;
            4, 5, 6, 9: return 12;
            7:          return 16;
            default:    return 8;
        endcase
    endfunction

    function automatic logic [31:0] pat(int s, int w);
        return 32'hC0DE_0000 | 32'(s << 8) | 32'(w);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_wr(input int s, input int w, input logic [31:0] dat);
        wr_en = 1'b1; wr_slot = 4'(s); wr_word = 4'(w); wr_data = dat;
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input int s, input int w);
        rd_en = 1'b1; rd_slot = 4'(s); rd_word = 4'(w);
        step();
        rd_en = 1'b0;
    endtask

    task automatic load(input int s);
        for (int w = 0; w < nwords(s); w++) do_wr(s, w, pat(s, w));
    endtask

    task automatic reload_all();
        for (int s = 0; s < 10; s++) load(s);
    endtask

    task automatic fire(input logic [3:0] ev);
        {op_zero, pwr_loss, reboot_req, sess_end} = ev;
        step();
        {op_zero, pwr_loss, reboot_req, sess_end} = 4'b0000;
    endtask

    task automatic wait_wipe(output int n);
        n = 0;
        while (zbusy && n < 2000) begin
            n++;
            step();
        end
    endtask

    task automatic t_reset();
        chk("R12 valid", 32'(slot_valid), 32'h0);
        chk("R12 zbusy", 32'(zbusy), 32'h0);
        chk("R12 zdone", 32'(zdone), 32'h0);
        chk("R12 acc_err", 32'(acc_err), 32'h0);
        chk("R12 rd_data", rd_data, 32'h0);
    endtask

    task automatic t_load();
        for (int w = 0; w < 7; w++) do_wr(0, w, pat(0, w));
        chk("R1 valid before last word", 32'(slot_valid[0]), 32'h0);
        do_wr(0, 7, pat(0, 7));
        chk("R1 valid after last word", 32'(slot_valid[0]), 32'h1);
        for (int s = 1; s < 12; s++) load(s);
        chk("R1 all valid", 32'(slot_valid), 32'hFFF);
        do_rd(0, 3);
        chk("R1 read data key", rd_data, pat(0, 3));
        chk("R1 read err", 32'(acc_err), 32'h0);
        do_rd(7, 15);
        chk("R1 read entropy top", rd_data, pat(7, 15));
    endtask

    task automatic t_session();
        int n;
        fire(4'b0001);
        chk("R2 valid after session end", 32'(slot_valid), 32'hFC0);
        chk("R6 busy raised", 32'(zbusy), 32'h1);
        wait_wipe(n);
        chk("R6 session word count", 32'(n), 32'd52);
        chk("R6 done pulse", 32'(zdone), 32'h1);
        step();
        chk("R6 done single cycle", 32'(zdone), 32'h0);
        do_rd(6, 0);
        chk("R2 seed kept", rd_data, pat(6, 0));
        do_rd(0, 0);
        chk("R11 invalid read data", rd_data, 32'h0);
        chk("R11 invalid read err", 32'(acc_err), 32'h1);
        do_wr(0, 7, pat(0, 7));
        do_rd(0, 0);
        chk("R2 words overwritten", rd_data, 32'h0);
        chk("R2 revalidated read ok", 32'(acc_err), 32'h0);
        do_rd(0, 7);
        chk("R2 rewritten word", rd_data, pat(0, 7));
    endtask

    task automatic t_reboot();
        int n;
        reload_all();
        fire(4'b0010);
        chk("R3 valid after reboot", 32'(slot_valid), 32'hF80);
        wait_wipe(n);
        chk("R3 reboot word count", 32'(n), 32'd64);
        do_rd(7, 9);
        chk("R3 entropy kept", rd_data, pat(7, 9));
        do_rd(6, 5);
        chk("R3 seed refused", 32'(acc_err), 32'h1);
    endtask

    task automatic t_power();
        int n;
        reload_all();
        fire(4'b0100);
        chk("R4 valid after power loss", 32'(slot_valid), 32'hF00);
        wait_wipe(n);
        chk("R4 power word count", 32'(n), 32'd80);
        do_rd(8, 2);
        chk("R4 kek kept", rd_data, pat(8, 2));
    endtask

    task automatic t_command();
        int n;
        reload_all();
        fire(4'b1000);
        chk("R5 valid after command", 32'(slot_valid), 32'hC00);
        wait_wipe(n);
        chk("R5 command word count", 32'(n), 32'd88);
        do_rd(9, 0);
        chk("R5 wrapped entry refused", 32'(acc_err), 32'h1);
        chk("R5 wrapped entry data", rd_data, 32'h0);
        do_rd(11, 4);
        chk("R5 master key kept", rd_data, pat(11, 4));
    endtask

    task automatic t_union();
        int n;
        reload_all();
        fire(4'b0101);
        chk("R7 valid after union", 32'(slot_valid), 32'hF00);
        wait_wipe(n);
        chk("R7 union word count", 32'(n), 32'd80);
        chk("R7 done", 32'(zdone), 32'h1);
        step();
        chk("R7 single pass", 32'({zbusy, zdone}), 32'h0);
    endtask

    task automatic t_factory();
        do_rd(10, 0);
        chk("R8 root data", rd_data, 32'h0);
        chk("R8 root err", 32'(acc_err), 32'h1);
        do_wr(11, 0, 32'hDEAD_BEEF);
        chk("R9 rewrite err", 32'(acc_err), 32'h1);
        do_rd(11, 0);
        chk("R9 master unchanged", rd_data, pat(11, 0));
        do_wr(10, 0, 32'h1234_5678);
        chk("R9 root rewrite err", 32'(acc_err), 32'h1);
    endtask

    task automatic t_crit();
        reload_all();
        crit_err = 1'b1;
        do_rd(0, 1);
        chk("R10 blocked data", rd_data, 32'h0);
        chk("R10 blocked err", 32'(acc_err), 32'h1);
        crit_err = 1'b0;
        do_rd(0, 1);
        chk("R10 released data", rd_data, pat(0, 1));
    endtask

    task automatic t_busy_write();
        int n;
        fire(4'b0001);
        do_wr(8, 0, 32'hDEAD_BEEF);
        chk("R11 busy write err", 32'(acc_err), 32'h1);
        wait_wipe(n);
        do_rd(8, 0);
        chk("R11 busy write ignored", rd_data, pat(8, 0));
        do_rd(13, 0);
        chk("R11 bad slot err", 32'(acc_err), 32'h1);
        do_rd(1, 9);
        chk("R11 bad word err", 32'(acc_err), 32'h1);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_session();
        t_reboot();
        t_power();
        t_command();
        t_union();
        t_factory();
        t_crit();
        t_busy_write();
        summary();
        $finish;
    end

endmodule